// File: doc/BRIEF.md
# Averaging Four-Channel ADC Conversion Sequencer

This block sits between a 32-bit register port and an external successive-approximation converter core. Software configures up to four logical channels. Each one picks one of sixteen physical inputs, runs either once or repeatedly, and may average 4, 8, 16 or 32 raw samples. The block then serves the enabled channels in turn. It issues one-cycle start pulses to the core, paced by a prescaled sample timer. It accumulates the returned 12-bit samples and posts each finished result into a packed result word. Each channel has a sticky done flag and a sticky timeout flag, and each flag can raise a single interrupt line.

A per-channel conversion passes through four engine states:
- ST_IDLE: waits for an enabled channel. It goes to ST_PACE once it has chosen the channel (the pick transition).
- ST_PACE: waits until the sample slot has elapsed. It then fires a start and goes to ST_CONV (the launch transition).
- ST_CONV: waits for the core's done strobe. When the last sample arrives it goes to ST_POST (the finish transition). When a sample arrives but more are needed it returns to ST_PACE (the next-sample transition). When the watchdog expires it returns to ST_IDLE (the expire transition).
- ST_POST: writes the result and the done flag, then returns to ST_IDLE (the retire transition).

Whenever the global gate is closed, the engine is forced back to ST_IDLE (the abort transition).

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the global configuration word at 0x130 reads 0x8000_0002 (power-down and clock-down set, converter off). Every other register reads 0, and irq is 0.
- R2: Channel n's setup word at n*0x20 keeps bit 31 (enable), bit 30 (one-shot), bit 29 (average) and bits 27:24 (input select). Its average word at n*0x20+0x10 keeps bits 13:12. The timer word at 0x90 keeps bits 31:29 (prescale code) and bits 7:0 (time unit T). The enable words at 0xC0 and 0xD0 keep bits 11:8. The global word keeps bits 31, 1 and 0. All other bits read as 0.
- R3: No start pulse is issued unless global bit 0 is 1 and bits 1 and 31 are both 0.
- R4: In one-shot mode, a finished conversion writes its result, sets done flag bit 8+n at 0xE0, and clears the channel's enable bit. Channels 0 and 1 post to bits 11:0 and 27:16 of 0xF0. Channels 2 and 3 post to the same fields of 0x100.
- R5: In continuous mode, the enable bit stays set and the channel is converted again on each pass. After the enable bit is cleared, the conversion in progress still completes.
- R6: With averaging on, average code c (0..3) takes 4<<c samples. The result is their sum shifted right by 2+c, truncated to 12 bits. With averaging off, one sample is stored.
- R7: Enabled channels are served round-robin, starting after the last channel served. Out of reset the order is 0, 1, 2, 3.
- R8: If done does not arrive within 1024 prescaled clocks of a start, timeout flag bit 16+n is set, no result is written, and no done flag is set.
- R9: Reads leave the status flags unchanged. Writing 0 to a flag bit clears it. Writing 1 leaves it as it is.
- R10: irq is 1 exactly when some channel n has a done or timeout flag set and bit 8+n is set in both 0xC0 and 0xD0.
- R11: Unaligned or unmapped offsets read 0. Writes to 0xF0 and 0x100 change nothing.
- R12: core_sel carries the select field of the channel being converted.
- R13: Prescale codes 0..5 divide the clock by 4..128, and codes above 5 act as 5. Starts within one averaged conversion are spaced exactly (T+1)*6 prescaled clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| core_start | output | 1 | One-cycle request for a sample |
| core_sel | output | 4 | Physical input for the current sample |
| core_done | input | 1 | Sample-ready strobe from the core |
| core_data | input | 12 | Sample value, valid with core_done |
| irq | output | 1 | Interrupt request |

## Verification
If the engine's channel pointer goes wrong, the log of core_sel values shows an out-of-order input on the very next start. A wrong sample count or a wrong shift appears in the packed result word as soon as the done flag sets. A pace counter that loads or decrements wrongly changes the measured gap between starts at the second sample. A broken watchdog moves the timeout flag away from the 4096-cycle mark, or lets a result or done flag appear where none should. Errors in status merging show up at the next read of 0xE0 or on irq in the same cycle.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_PACE, ST_CONV, ST_POST} seq_state_t;

    localparam logic [8:0] A_TMR  = 9'h090;
    localparam logic [8:0] A_SIG  = 9'h0C0;
    localparam logic [8:0] A_IEN  = 9'h0D0;
    localparam logic [8:0] A_STAT = 9'h0E0;
    localparam logic [8:0] A_RES0 = 9'h0F0;
    localparam logic [8:0] A_RES1 = 9'h100;
    localparam logic [8:0] A_GCFG = 9'h130;
endpackage

// File: rtl/adcseq_tick.sv
module adcseq_tick #(
    parameter int CODE_W   = 3,
    parameter int MAX_CODE = 5,
    parameter int CNT_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        if (int'(code) > MAX_CODE) lim = CNT_W'((4 << MAX_CODE) - 1);
        else                       lim = CNT_W'((4 << code) - 1);
    end

    assign tick = run && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    // R13: the divider never yields back-to-back ticks
    assert_tick_gap_R13: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/adcseq_engine.sv
module adcseq_engine
    import adcseq_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int DW        = 12,
    parameter int T_W       = 8,
    parameter int TMO_TICKS = 1024,
    localparam int CH_W     = $clog2(NCH),
    localparam int ACC_W    = DW + 5,
    localparam int PACE_W   = T_W + 3,
    localparam int WD_W     = $clog2(TMO_TICKS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     tick,
    input  logic [NCH-1:0]           en,
    input  logic [NCH-1:0]           avg,
    input  logic [NCH-1:0][3:0]      sel,
    input  logic [NCH-1:0][1:0]      avgc,
    input  logic [T_W-1:0]           tunit,
    input  logic                     core_done,
    input  logic [DW-1:0]            core_data,
    output logic                     core_start,
    output logic [3:0]               core_sel,
    output logic                     post_valid,
    output logic [CH_W-1:0]          post_ch,
    output logic [DW-1:0]            post_data,
    output logic                     tmo_valid
);
    seq_state_t        state, nstate;
    logic [CH_W-1:0]   cur, ptr, pick;
    logic              found;
    logic [ACC_W-1:0]  acc;
    logic [5:0]        nsmp, target;
    logic [2:0]        shift;
    logic [PACE_W-1:0] pace;
    logic [WD_W-1:0]   wd;

    always_comb begin
        logic [CH_W-1:0] idx;
        found = 1'b0;
        pick  = ptr;
        for (int i = NCH - 1; i >= 0; i--) begin
            idx = ptr + CH_W'(i);
            if (en[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end

    assign target    = avg[cur] ? 6'(4 << avgc[cur]) : 6'd1;
    assign shift     = avg[cur] ? 3'(2 + avgc[cur]) : 3'd0;
    assign post_data = DW'(acc >> shift);
    assign post_ch   = cur;
    assign core_sel  = sel[cur];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate     = state;
        core_start = 1'b0;
        post_valid = 1'b0;
        tmo_valid  = 1'b0;
        if (run) begin
            unique case (state)
                ST_IDLE: if (found) nstate = ST_PACE;
                ST_PACE: if (pace == '0) begin
                    core_start = 1'b1;
                    nstate     = ST_CONV;
                end
                ST_CONV: begin
                    if (core_done)
                        nstate = (6'(nsmp + 6'd1) == target) ? ST_POST : ST_PACE;
                    else if (tick && wd == WD_W'(TMO_TICKS - 1)) begin
                        tmo_valid = 1'b1;
                        nstate    = ST_IDLE;
                    end
                end
                ST_POST: begin
                    post_valid = 1'b1;
                    nstate     = ST_IDLE;
                end
            endcase
        end else begin
            nstate = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0; ptr <= '0; acc <= '0; nsmp <= '0; pace <= '0; wd <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (found) begin
                    cur <= pick; acc <= '0; nsmp <= '0; pace <= '0;
                end
                ST_PACE: begin
                    if (pace == '0) begin
                        pace <= PACE_W'((32'(tunit) + 1) * 6);
                        wd   <= '0;
                    end else if (tick) begin
                        pace <= pace - 1'b1;
                    end
                end
                ST_CONV: begin
                    if (tick && pace != '0) pace <= pace - 1'b1;
                    if (core_done) begin
                        acc  <= acc + ACC_W'(core_data);
                        nsmp <= nsmp + 6'd1;
                    end else if (tick) begin
                        wd <= wd + 1'b1;
                    end
                    if (tmo_valid) ptr <= cur + 1'b1;
                end
                ST_POST: ptr <= cur + 1'b1;
            endcase
        end
    end

    // R13: a start is a single-cycle pulse
    assert_start_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);
    // R8: the watchdog never runs past its limit
    assert_wd_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd <= WD_W'(TMO_TICKS));
    // R6: a post only follows a conversion wait
    assert_post_after_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |-> $past(state) == ST_CONV);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adcseq_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int DW        = 12,
    parameter int T_W       = 8,
    parameter int TMO_TICKS = 1024,
    localparam int CH_W     = $clog2(NCH),
    localparam int CFG_SPAN = NCH * 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [8:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        core_start,
    output logic [3:0]  core_sel,
    input  logic        core_done,
    input  logic [11:0] core_data,
    output logic        irq
);
    logic [NCH-1:0]          cfg_en, cfg_single, cfg_avg;
    logic [NCH-1:0][3:0]     cfg_sel;
    logic [NCH-1:0][1:0]     cfg_avgc;
    logic [NCH-1:0][DW-1:0]  res_q;
    logic [2:0]              tmr_code;
    logic [T_W-1:0]          tmr_t;
    logic [NCH-1:0]          sig_en, int_en, st_done, st_tmo;
    logic                    g_en, g_pd, g_cd, run, tick;
    logic                    post_valid, tmo_valid;
    logic [CH_W-1:0]         post_ch;
    logic [DW-1:0]           post_data;
    logic                    in_cfg, wr_stat;
    logic [CH_W-1:0]         cfg_ch;
    logic [NCH-1:0]          wr_cfg1, wr_cfg2, done_set, tmo_set;
    logic                    unused_wbits;

    assign unused_wbits = ^{reg_wdata[28], reg_wdata[23:20], reg_wdata[15:14]};
    assign run      = g_en && !g_pd && !g_cd;
    assign in_cfg   = (reg_addr < 9'(CFG_SPAN)) && (reg_addr[3:0] == 4'd0);
    assign cfg_ch   = reg_addr[CH_W+4:5];
    assign wr_stat  = reg_wr && reg_addr == A_STAT;
    assign done_set = post_valid ? (NCH'(1) << post_ch) : '0;
    assign tmo_set  = tmo_valid  ? (NCH'(1) << post_ch) : '0;
    assign irq      = |((st_done | st_tmo) & sig_en & int_en);

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_dec
            assign wr_cfg1[n] = reg_wr && in_cfg && !reg_addr[4] && cfg_ch == CH_W'(n);
            assign wr_cfg2[n] = reg_wr && in_cfg &&  reg_addr[4] && cfg_ch == CH_W'(n);

            // R4: one-shot retire clears the enable and raises done
            assert_oneshot_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (post_valid && post_ch == CH_W'(n) && cfg_single[n] && !wr_cfg1[n]) |=> !cfg_en[n]);
            assert_done_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (post_valid && post_ch == CH_W'(n)) |=> st_done[n]);
            // R8: an expired watchdog sets the timeout flag
            assert_tmo_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (tmo_valid && post_ch == CH_W'(n)) |=> st_tmo[n]);
        end
    endgenerate

    adcseq_tick #(.CODE_W(3), .MAX_CODE(5), .CNT_W(7)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .code(tmr_code), .tick(tick)
    );

    adcseq_engine #(.NCH(NCH), .DW(DW), .T_W(T_W), .TMO_TICKS(TMO_TICKS)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .en(cfg_en), .avg(cfg_avg), .sel(cfg_sel), .avgc(cfg_avgc), .tunit(tmr_t),
        .core_done(core_done), .core_data(core_data),
        .core_start(core_start), .core_sel(core_sel),
        .post_valid(post_valid), .post_ch(post_ch), .post_data(post_data),
        .tmo_valid(tmo_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en <= '0; cfg_single <= '0; cfg_avg <= '0; cfg_sel <= '0; cfg_avgc <= '0;
            res_q <= '0; tmr_code <= '0; tmr_t <= '0; sig_en <= '0; int_en <= '0;
            st_done <= '0; st_tmo <= '0;
            g_en <= 1'b0; g_pd <= 1'b1; g_cd <= 1'b1;
        end else begin
            if (post_valid) res_q[post_ch] <= post_data;
            for (int n = 0; n < NCH; n++) begin
                if (post_valid && post_ch == CH_W'(n) && cfg_single[n]) cfg_en[n] <= 1'b0;
                if (wr_cfg1[n]) begin
                    cfg_en[n]     <= reg_wdata[31];
                    cfg_single[n] <= reg_wdata[30];
                    cfg_avg[n]    <= reg_wdata[29];
                    cfg_sel[n]    <= reg_wdata[27:24];
                end
                if (wr_cfg2[n]) cfg_avgc[n] <= reg_wdata[13:12];
            end
            st_done <= (st_done & (wr_stat ? reg_wdata[8+:NCH]  : '1)) | done_set;
            st_tmo  <= (st_tmo  & (wr_stat ? reg_wdata[16+:NCH] : '1)) | tmo_set;
            if (reg_wr) begin
                unique case (reg_addr)
                    A_TMR:  begin tmr_code <= reg_wdata[31:29]; tmr_t <= reg_wdata[T_W-1:0]; end
                    A_SIG:  sig_en <= reg_wdata[8+:NCH];
                    A_IEN:  int_en <= reg_wdata[8+:NCH];
                    A_GCFG: begin g_cd <= reg_wdata[31]; g_pd <= reg_wdata[1]; g_en <= reg_wdata[0]; end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (in_cfg) begin
            if (!reg_addr[4])
                reg_rdata = {cfg_en[cfg_ch], cfg_single[cfg_ch], cfg_avg[cfg_ch], 1'b0,
                             cfg_sel[cfg_ch], 24'd0};
            else
                reg_rdata = {18'd0, cfg_avgc[cfg_ch], 12'd0};
        end else begin
            unique case (reg_addr)
                A_TMR:  reg_rdata = {tmr_code, 29'(tmr_t)};
                A_SIG:  reg_rdata = 32'(sig_en) << 8;
                A_IEN:  reg_rdata = 32'(int_en) << 8;
                A_STAT: reg_rdata = (32'(st_tmo) << 16) | (32'(st_done) << 8);
                A_RES0: reg_rdata = {4'd0, res_q[1], 4'd0, res_q[0]};
                A_RES1: reg_rdata = {4'd0, res_q[3], 4'd0, res_q[2]};
                A_GCFG: reg_rdata = {g_cd, 29'd0, g_pd, g_en};
                default: reg_rdata = '0;
            endcase
        end
    end

    // R3: no start while the global gate is closed
    assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_en || g_pd || g_cd) |-> !core_start);
    // R11: result words ignore writes
    assert_result_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_RES0 || reg_addr == A_RES1) && !post_valid)
        |=> ($stable(res_q)));
    // R9: writing ones keeps every flag
    assert_w1_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (&reg_wdata[8+:NCH]) && (&reg_wdata[16+:NCH]))
        |=> (((st_done & $past(st_done)) == $past(st_done)) &&
             ((st_tmo & $past(st_tmo)) == $past(st_tmo))));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_start;
    logic [3:0]  core_sel;
    logic        core_done = 1'b0;
    logic [11:0] core_data = '0;
    logic        irq;

    int nchk = 0;
    int nbad = 0;
    int cyc  = 0;

    // stub of the converter core
    logic        stub_clr = 1'b0;
    logic        stub_mute = 1'b0;
    logic [11:0] stub_base = '0;
    logic [11:0] stub_k = '0;
    logic [11:0] stub_pd = '0;
    int          stub_dly = 0;
    int          nlog = 0;
    logic [3:0]  sel_log [16];
    int          t_log [16];

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_start(core_start),
        .core_sel(core_sel), .core_done(core_done), .core_data(core_data), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        core_done <= 1'b0;
        if (stub_clr) begin
            stub_k <= '0; nlog <= 0; stub_dly <= 0;
        end else begin
            if (stub_dly != 0) begin
                stub_dly <= stub_dly - 1;
                if (stub_dly == 1) begin core_done <= 1'b1; core_data <= stub_pd; end
            end
            if (core_start) begin
                if (nlog < 16) begin sel_log[nlog] <= core_sel; t_log[nlog] <= cyc; end
                nlog <= nlog + 1;
                if (!stub_mute) begin
                    stub_dly <= 3; stub_pd <= stub_base + stub_k; stub_k <= stub_k + 1'b1;
                end
            end
        end
    end

    // register table: address, write value, read-back value (R2)
    localparam logic [95:0] VEC [8] = '{
        {32'h020, 32'hFFFF_FFFF, 32'hEF00_0000},
        {32'h030, 32'hFFFF_FFFF, 32'h0000_3000},
        {32'h090, 32'hFFFF_FFFF, 32'hE000_00FF},
        {32'h0C0, 32'hFFFF_FFFF, 32'h0000_0F00},
        {32'h0D0, 32'h1234_5678, 32'h0000_0600},
        {32'h130, 32'hFFFF_FFFF, 32'h8000_0003},
        {32'h130, 32'h8000_0002, 32'h8000_0002},
        {32'h020, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_stat(input logic [31:0] mask, input int limit);
        logic [31:0] v;
        for (int i = 0; i < limit; i++) begin
            rd(9'h0E0, v);
            if ((v & mask) == mask) break;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; stub_clr = 1'b1; stub_mute = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; stub_clr = 1'b0;
    endtask

    initial begin
        wait (cyc > WDOG_CYC);
        nbad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_CYC);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int t0, m;

        // R1: reset state
        do_reset();
        rd(9'h130, v); chk("R1 global reset", v, 32'h8000_0002);
        rd(9'h0F0, v); chk("R1 result reset", v, 32'h0);
        rd(9'h0E0, v); chk("R1 status reset", v, 32'h0);
        chk("R1 irq reset", 32'(irq), 32'h0);

        // R2: register table walk
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][72:64], VEC[i][63:32]);
            rd(VEC[i][72:64], v);
            chk("R2 field layout", v, VEC[i][31:0]);
        end

        // R3, R7, R12, R4: four one-shot channels
        do_reset();
        stub_base = 12'h100;
        for (int n = 0; n < 4; n++) wr(9'(n * 32), 32'hC000_0000 | (32'(5 + n) << 24));
        repeat (200) @(negedge clk);
        chk("R3 no start while down", 32'(nlog), 32'd0);
        wr(9'h130, 32'h0000_0003);
        repeat (200) @(negedge clk);
        chk("R3 no start with power-down", 32'(nlog), 32'd0);
        wr(9'h130, 32'h0000_0001);
        wait_stat(32'h0000_0F00, 2000);
        for (int n = 0; n < 4; n++) chk("R7 R12 order and select", 32'(sel_log[n]), 32'(5 + n));
        rd(9'h0F0, v); chk("R4 packed result A/B", v, 32'h0101_0100);
        rd(9'h100, v); chk("R4 packed result C/D", v, 32'h0103_0102);
        rd(9'h000, v); chk("R4 enable self-clear", v, 32'h4500_0000);
        repeat (100) @(negedge clk);
        chk("R4 one conversion each", 32'(nlog), 32'd4);

        // R10, R9: interrupt gating and status clearing
        wr(9'h0C0, 32'h0000_0100); wr(9'h0D0, 32'h0000_0200);
        #1 chk("R10 split enables no irq", 32'(irq), 32'h0);
        wr(9'h0D0, 32'h0000_0100);
        #1 chk("R10 both enables irq", 32'(irq), 32'h1);
        rd(9'h0E0, v); rd(9'h0E0, v2);
        chk("R9 read keeps flags", v2, 32'h0000_0F00);
        wr(9'h0E0, 32'hFFFF_FFFF);
        rd(9'h0E0, v); chk("R9 write one keeps", v, 32'h0000_0F00);
        wr(9'h0E0, 32'hFFFF_FEFF);
        rd(9'h0E0, v); chk("R9 write zero clears", v, 32'h0000_0E00);
        chk("R10 irq drops after clear", 32'(irq), 32'h0);

        // R11: unmapped, unaligned and read-only offsets
        rd(9'h0F2, v); chk("R11 unaligned read", v, 32'h0);
        rd(9'h0A0, v); chk("R11 unmapped read", v, 32'h0);
        wr(9'h0F0, 32'hFFFF_FFFF);
        rd(9'h0F0, v); chk("R11 result write ignored", v, 32'h0101_0100);

        // R6, R13: averaging over 8 and 32 samples
        do_reset();
        stub_base = 12'h200;
        wr(9'h090, 32'h0000_0001);
        wr(9'h050, 32'h0000_1000);
        wr(9'h040, 32'hE300_0000);
        wr(9'h130, 32'h0000_0001);
        wait_stat(32'h0000_0400, 3000);
        rd(9'h100, v); chk("R6 average of 8", v, 32'h0000_0203);
        chk("R13 start spacing", 32'(t_log[2] - t_log[1]), 32'd48);
        chk("R6 eight samples", 32'(nlog), 32'd8);
        @(negedge clk); stub_clr = 1'b1; @(negedge clk); stub_clr = 1'b0;
        stub_base = 12'h7F0;
        wr(9'h070, 32'h0000_3000);
        wr(9'h060, 32'hE900_0000);
        wait_stat(32'h0000_0800, 6000);
        rd(9'h100, v); chk("R6 average of 32", v, 32'h07FF_0203);
        chk("R6 thirty-two samples", 32'(nlog), 32'd32);

        // R5: continuous mode with averaging over 4
        do_reset();
        stub_base = 12'h010;
        wr(9'h020, 32'hA200_0000);
        wr(9'h130, 32'h0000_0001);
        for (int i = 0; i < 3000 && nlog < 12; i++) @(negedge clk);
        rd(9'h020, v); chk("R5 enable stays set", v, 32'hA200_0000);
        rd(9'h0E0, v); chk("R5 done flag", v & 32'h200, 32'h200);
        wr(9'h020, 32'h2200_0000);
        repeat (400) @(negedge clk);
        chk("R5 whole conversions", 32'(nlog % 4), 32'd0);
        m = nlog / 4;
        rd(9'h0F0, v);
        chk("R5 last average", v, 32'(12'(16 + 4 * (m - 1) + 1)) << 16);

        // R8: watchdog timeout
        do_reset();
        stub_mute = 1'b1;
        wr(9'h0C0, 32'h0000_0100); wr(9'h0D0, 32'h0000_0100);
        wr(9'h000, 32'hC100_0000);
        wr(9'h130, 32'h0000_0001);
        t0 = cyc;
        wait_stat(32'h0001_0000, 6000);
        chk("R8 timeout not early", 32'(cyc - t0 >= 4096), 32'd1);
        chk("R8 timeout not late", 32'(cyc - t0 < 4120), 32'd1);
        rd(9'h0E0, v); chk("R8 timeout only", v & 32'h0001_0F00, 32'h0001_0000);
        rd(9'h0F0, v); chk("R8 no result written", v, 32'h0);
        chk("R10 timeout raises irq", 32'(irq), 32'h1);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule